// File: doc/BRIEF.md
# Serial Port Control and Channel-Mode Router

This block holds the control register and the mode register of a serial port and steers every byte to the right place. Bytes arrive from two sources, bus writes to the data register and bytes coming in from the serial line. They leave toward two sinks, the receive FIFO and the transmit FIFO. A 2-bit channel mode picks the routes. Normal mode sends line bytes to the receive FIFO and bus bytes to the transmit FIFO. Echo mode copies line bytes into both FIFOs and throws bus bytes away. Local loopback sends bus bytes into the receive FIFO and drops line bytes. Remote loopback sends line bytes to the transmit FIFO and throws bus bytes away.

Reception and transmission each have an enable bit and a disable bit, and the disable bit wins. The two FIFO-reset bits produce one-cycle pulses and never read back as 1. A start/stop bit pair requests a break. The FIFO storage, the serializer and the interrupt logic sit outside this block. It sees only the FIFOs' full and empty flags, and it drives their push strobes, their pop strobe and two overrun events.

Back-pressure rules: the bus write stream (`bw_*`) is always ready. A byte it cannot place is dropped and reported as an overrun event. The line stream (`ln_*`) is also always ready, with one exception: in echo mode `ln_ready` falls while either FIFO is full, so a line byte is taken only when both copies fit. A transfer happens on a cycle where valid and ready are both high. The push and event outputs are combinational in that same cycle.

Top module: `sio_chan_router`

## Requirements
- R1: After reset the control register reads 0x128. Receive and transmit are disabled, no break is requested, the mode register reads 0 (normal mode), and both FIFO-reset pulses are low.
- R2: Writing control bit 0 (receive) or bit 1 (transmit) as 1 raises `rxf_rst` or `txf_rst` for exactly the one cycle that follows the write. Both bits read back as 0. A write with a bit at 0 gives no pulse.
- R3: `rx_en` is high only while control bit 2 is 1 and bit 3 is 0. `tx_en` is high only while control bit 4 is 1 and bit 5 is 0.
- R4: `brk_req` is high only while control bit 7 is 1 and bit 8 is 0.
- R5: The channel mode is mode-register bits 9:8, and `chan_mode` shows it. The encodings are 0 normal, 1 echo, 2 local loopback and 3 remote loopback.
- R6: An accepted line byte is pushed to the receive FIFO in normal and echo modes and to the transmit FIFO in echo and remote loopback modes. It is dropped in local loopback. The pushed data equals `ln_data`.
- R7: A bus data write is pushed to the transmit FIFO in normal mode and to the receive FIFO in local loopback, with data equal to `bw_data`. It is discarded in echo and remote loopback modes.
- R8: A byte routed to a disabled path is discarded with no push and no overrun event, whatever the FIFO flags.
- R9: A byte routed to an enabled receive path while `rxf_full` is high is not pushed, and `rx_ovr` pulses in that cycle.
- R10: A byte routed to an enabled transmit path while `txf_full` is high is not pushed, and `tx_ovf` pulses in that cycle.
- R11: In echo mode `ln_ready` is low while either FIFO is full. No push and no event then happen. With both FIFOs having room, one line byte is pushed to both FIFOs together.
- R12: A data read (`rd_req`) with the receiver enabled and `rxf_empty` low returns `rxf_rdata` and pulses `rxf_pop`. Otherwise it returns 0 and does not pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | CTL_W | Control register write value |
| ctl_rdata | output | CTL_W | Control register read value |
| mode_wr | input | 1 | Mode register write strobe |
| mode_wdata | input | MODE_W | Mode register write value |
| mode_rdata | output | MODE_W | Mode register read value |
| chan_mode | output | 2 | Current channel mode |
| rx_en | output | 1 | Receive path active |
| tx_en | output | 1 | Transmit path active |
| brk_req | output | 1 | Break requested |
| rxf_rst | output | 1 | One-cycle receive FIFO reset |
| txf_rst | output | 1 | One-cycle transmit FIFO reset |
| bw_valid | input | 1 | Bus data write valid |
| bw_ready | output | 1 | Bus data write ready (always 1) |
| bw_data | input | DW | Bus data write byte |
| ln_valid | input | 1 | Line byte valid |
| ln_ready | output | 1 | Line byte ready |
| ln_data | input | DW | Line byte |
| rd_req | input | 1 | Bus data read request |
| rd_data | output | DW | Bus data read value |
| rxf_push | output | 1 | Receive FIFO push |
| rxf_wdata | output | DW | Receive FIFO push data |
| rxf_full | input | 1 | Receive FIFO full |
| rxf_empty | input | 1 | Receive FIFO empty |
| rxf_rdata | input | DW | Receive FIFO head byte |
| rxf_pop | output | 1 | Receive FIFO pop |
| txf_push | output | 1 | Transmit FIFO push |
| txf_wdata | output | DW | Transmit FIFO push data |
| txf_full | input | 1 | Transmit FIFO full |
| rx_ovr | output | 1 | Receive overrun event |
| tx_ovf | output | 1 | Transmit overflow event |

## Verification
Each of the four modes gets a line byte and, separately, a bus byte, each with its own data value. The two push strobes and the data then show which of the four routes each mode opens. Those cases run with every FIFO flag clear. The same sources are then applied with one FIFO full at a time, so a dropped byte with its event can be told apart from a stall on `ln_ready` (echo only) and from a silent discard on a disabled path. Control-register patterns switch the enable or disable bit of one pair at a time, which separates "disable wins" from "enable wins". They also check that the reset bits pulse once and read back as zero.

// File: rtl/sio_router_pkg.sv
package sio_router_pkg;

  typedef enum logic [1:0] {
    CH_NORMAL = 2'd0,
    CH_ECHO   = 2'd1,
    CH_LOCAL  = 2'd2,
    CH_REMOTE = 2'd3
  } chan_mode_e;

  // control register bit positions (behavioural: software encodes them)
  localparam int unsigned CB_RX_RST  = 0;
  localparam int unsigned CB_TX_RST  = 1;
  localparam int unsigned CB_RX_ON   = 2;
  localparam int unsigned CB_RX_OFF  = 3;
  localparam int unsigned CB_TX_ON   = 4;
  localparam int unsigned CB_TX_OFF  = 5;
  localparam int unsigned CB_BRK_GO  = 7;
  localparam int unsigned CB_BRK_END = 8;

endpackage

// File: rtl/sio_ctl_regs.sv
module sio_ctl_regs
  import sio_router_pkg::*;
#(
  parameter int unsigned CTL_W    = 9,
  parameter int unsigned MODE_W   = 10,
  parameter int unsigned MODE_LSB = 8,
  parameter logic [CTL_W-1:0] CTL_RST = 9'h128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic [CTL_W-1:0]  ctl_wdata,
  input  logic              mode_wr,
  input  logic [MODE_W-1:0] mode_wdata,
  output logic [CTL_W-1:0]  ctl_q,
  output logic [MODE_W-1:0] mode_q,
  output chan_mode_e        mode_o,
  output logic              rx_en_o,
  output logic              tx_en_o,
  output logic              brk_o,
  output logic              rxf_rst_o,
  output logic              txf_rst_o
);

  localparam logic [CTL_W-1:0] SELF_CLR =
    (CTL_W'(1) << CB_RX_RST) | (CTL_W'(1) << CB_TX_RST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q     <= CTL_RST & ~SELF_CLR;
      mode_q    <= '0;
      rxf_rst_o <= 1'b0;
      txf_rst_o <= 1'b0;
    end else begin
      rxf_rst_o <= ctl_wr & ctl_wdata[CB_RX_RST];
      txf_rst_o <= ctl_wr & ctl_wdata[CB_TX_RST];
      if (ctl_wr)  ctl_q  <= ctl_wdata & ~SELF_CLR;
      if (mode_wr) mode_q <= mode_wdata;
    end
  end

  always_comb begin
    mode_o  = chan_mode_e'(mode_q[MODE_LSB +: 2]);
    rx_en_o = ctl_q[CB_RX_ON] & ~ctl_q[CB_RX_OFF];
    tx_en_o = ctl_q[CB_TX_ON] & ~ctl_q[CB_TX_OFF];
    brk_o   = ctl_q[CB_BRK_GO] & ~ctl_q[CB_BRK_END];
  end

  AST_RXRST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_wdata[CB_RX_RST]) |=> (rxf_rst_o && ctl_q[CB_RX_RST] == 1'b0)); // R2
  AST_TXRST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (txf_rst_o && !$past(ctl_wr)) |-> 1'b0); // R2
  AST_RX_DISABLE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_wdata[CB_RX_OFF]) |=> !rx_en_o); // R3

endmodule

// File: rtl/sio_push_gate.sv
module sio_push_gate #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_i,
  input  logic [DW-1:0] data_i,
  input  logic          path_en_i,
  input  logic          full_i,
  output logic          push_o,
  output logic [DW-1:0] wdata_o,
  output logic          ovf_o
);

  always_comb begin
    push_o  = req_i & path_en_i & ~full_i;
    ovf_o   = req_i & path_en_i & full_i;
    wdata_o = data_i;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push_o |-> !full_i); // R9
  AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !path_en_i |-> (!push_o && !ovf_o)); // R8

endmodule

// File: rtl/sio_mode_route.sv
module sio_mode_route
  import sio_router_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  chan_mode_e    mode_i,
  input  logic          rx_en_i,
  input  logic          tx_en_i,
  input  logic          bw_valid,
  output logic          bw_ready,
  input  logic [DW-1:0] bw_data,
  input  logic          ln_valid,
  output logic          ln_ready,
  input  logic [DW-1:0] ln_data,
  input  logic          rxf_full,
  input  logic          txf_full,
  output logic          rxf_push,
  output logic [DW-1:0] rxf_wdata,
  output logic          txf_push,
  output logic [DW-1:0] txf_wdata,
  output logic          rx_ovr,
  output logic          tx_ovf
);

  localparam int unsigned NSINK = 2; // 0 = receive FIFO, 1 = transmit FIFO

  logic          ln_fire;
  logic          ln_to_rx, ln_to_tx, bus_to_rx, bus_to_tx;
  logic [NSINK-1:0]         sink_req, sink_en, sink_full, sink_push, sink_ovf;
  logic [NSINK-1:0][DW-1:0] sink_data, sink_wdata;

  always_comb begin
    ln_to_rx  = (mode_i == CH_NORMAL) || (mode_i == CH_ECHO);
    ln_to_tx  = (mode_i == CH_ECHO)   || (mode_i == CH_REMOTE);
    bus_to_rx = (mode_i == CH_LOCAL);
    bus_to_tx = (mode_i == CH_NORMAL);
    bw_ready  = 1'b1;
    ln_ready  = (mode_i == CH_ECHO) ? ~(rxf_full | txf_full) : 1'b1;
    ln_fire   = ln_valid & ln_ready;

    // the two sources never aim at the same sink in one mode
    sink_req[0]  = (ln_fire & ln_to_rx) | (bw_valid & bus_to_rx);
    sink_data[0] = bus_to_rx ? bw_data : ln_data;
    sink_en[0]   = rx_en_i;
    sink_full[0] = rxf_full;
    sink_req[1]  = (ln_fire & ln_to_tx) | (bw_valid & bus_to_tx);
    sink_data[1] = bus_to_tx ? bw_data : ln_data;
    sink_en[1]   = tx_en_i;
    sink_full[1] = txf_full;
  end

  for (genvar g = 0; g < NSINK; g++) begin : g_sink
    sio_push_gate #(.DW(DW)) u_gate (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_i     (sink_req[g]),
      .data_i    (sink_data[g]),
      .path_en_i (sink_en[g]),
      .full_i    (sink_full[g]),
      .push_o    (sink_push[g]),
      .wdata_o   (sink_wdata[g]),
      .ovf_o     (sink_ovf[g])
    );
  end

  always_comb begin
    rxf_push  = sink_push[0];
    rxf_wdata = sink_wdata[0];
    rx_ovr    = sink_ovf[0];
    txf_push  = sink_push[1];
    txf_wdata = sink_wdata[1];
    tx_ovf    = sink_ovf[1];
  end

  AST_ECHO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == CH_ECHO && (rxf_full || txf_full)) |-> (!ln_ready && !rxf_push && !txf_push)); // R11
  AST_TX_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    txf_push |-> !txf_full); // R10
  AST_BUS_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == CH_REMOTE) |-> !rxf_push); // R7

endmodule

// File: rtl/sio_rx_read.sv
module sio_rx_read #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_req,
  input  logic          rx_en_i,
  input  logic          rxf_empty,
  input  logic [DW-1:0] rxf_rdata,
  output logic          rxf_pop,
  output logic [DW-1:0] rd_data
);

  always_comb begin
    rxf_pop = rd_req & rx_en_i & ~rxf_empty;
    rd_data = rxf_pop ? rxf_rdata : '0;
  end

  AST_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && (rxf_empty || !rx_en_i)) |-> (rd_data == '0 && !rxf_pop)); // R12

endmodule

// File: rtl/sio_chan_router.sv
module sio_chan_router
  import sio_router_pkg::*;
#(
  parameter int unsigned DW       = 8,
  parameter int unsigned CTL_W    = 9,
  parameter int unsigned MODE_W   = 10,
  parameter int unsigned MODE_LSB = 8,
  parameter logic [CTL_W-1:0] CTL_RST = 9'h128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic [CTL_W-1:0]  ctl_wdata,
  output logic [CTL_W-1:0]  ctl_rdata,
  input  logic              mode_wr,
  input  logic [MODE_W-1:0] mode_wdata,
  output logic [MODE_W-1:0] mode_rdata,
  output logic [1:0]        chan_mode,
  output logic              rx_en,
  output logic              tx_en,
  output logic              brk_req,
  output logic              rxf_rst,
  output logic              txf_rst,
  input  logic              bw_valid,
  output logic              bw_ready,
  input  logic [DW-1:0]     bw_data,
  input  logic              ln_valid,
  output logic              ln_ready,
  input  logic [DW-1:0]     ln_data,
  input  logic              rd_req,
  output logic [DW-1:0]     rd_data,
  output logic              rxf_push,
  output logic [DW-1:0]     rxf_wdata,
  input  logic              rxf_full,
  input  logic              rxf_empty,
  input  logic [DW-1:0]     rxf_rdata,
  output logic              rxf_pop,
  output logic              txf_push,
  output logic [DW-1:0]     txf_wdata,
  input  logic              txf_full,
  output logic              rx_ovr,
  output logic              tx_ovf
);

  chan_mode_e mode_e;

  sio_ctl_regs #(
    .CTL_W(CTL_W), .MODE_W(MODE_W), .MODE_LSB(MODE_LSB), .CTL_RST(CTL_RST)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_wr     (ctl_wr),
    .ctl_wdata  (ctl_wdata),
    .mode_wr    (mode_wr),
    .mode_wdata (mode_wdata),
    .ctl_q      (ctl_rdata),
    .mode_q     (mode_rdata),
    .mode_o     (mode_e),
    .rx_en_o    (rx_en),
    .tx_en_o    (tx_en),
    .brk_o      (brk_req),
    .rxf_rst_o  (rxf_rst),
    .txf_rst_o  (txf_rst)
  );

  assign chan_mode = mode_e;

  sio_mode_route #(.DW(DW)) u_route (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_i    (mode_e),
    .rx_en_i   (rx_en),
    .tx_en_i   (tx_en),
    .bw_valid  (bw_valid),
    .bw_ready  (bw_ready),
    .bw_data   (bw_data),
    .ln_valid  (ln_valid),
    .ln_ready  (ln_ready),
    .ln_data   (ln_data),
    .rxf_full  (rxf_full),
    .txf_full  (txf_full),
    .rxf_push  (rxf_push),
    .rxf_wdata (rxf_wdata),
    .txf_push  (txf_push),
    .txf_wdata (txf_wdata),
    .rx_ovr    (rx_ovr),
    .tx_ovf    (tx_ovf)
  );

  sio_rx_read #(.DW(DW)) u_read (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_req    (rd_req),
    .rx_en_i   (rx_en),
    .rxf_empty (rxf_empty),
    .rxf_rdata (rxf_rdata),
    .rxf_pop   (rxf_pop),
    .rd_data   (rd_data)
  );

  AST_BRK_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_wdata[CB_BRK_END]) |=> !brk_req); // R4
  AST_LOCAL_LINE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_e == CH_LOCAL && !bw_valid) |-> (!rxf_push && !txf_push)); // R6

endmodule

// File: tb/sio_chan_router_tb_top.sv
module sio_chan_router_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        ctl_wr = 0, mode_wr = 0;
  logic [8:0]  ctl_wdata = '0, ctl_rdata;
  logic [9:0]  mode_wdata = '0, mode_rdata;
  logic [1:0]  chan_mode;
  logic        rx_en, tx_en, brk_req, rxf_rst, txf_rst;
  logic        bw_valid = 0, bw_ready, ln_valid = 0, ln_ready, rd_req = 0;
  logic [7:0]  bw_data = '0, ln_data = '0, rd_data, rxf_wdata, txf_wdata, rxf_rdata = '0;
  logic        rxf_push, rxf_full = 0, rxf_empty = 1, rxf_pop, txf_push, txf_full = 0;
  logic        rx_ovr, tx_ovf;

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  sio_chan_router dut_i (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_ctl(input logic [8:0] v);
    @(negedge clk); ctl_wr = 1; ctl_wdata = v;
    @(negedge clk); ctl_wr = 0;
  endtask

  task automatic wr_mode(input logic [1:0] m);
    @(negedge clk); mode_wr = 1; mode_wdata = {m, 8'h3C};
    @(negedge clk); mode_wr = 0;
  endtask

  task automatic idle_inputs();
    bw_valid = 0; ln_valid = 0; rd_req = 0; rxf_full = 0; txf_full = 0; rxf_empty = 1;
  endtask

  task automatic t_reset();
    chk("R1 ctl", ctl_rdata, 9'h128);
    chk("R1 rx_en", rx_en, 0);
    chk("R1 tx_en", tx_en, 0);
    chk("R1 brk", brk_req, 0);
    chk("R1 mode", mode_rdata, 0);
    chk("R1 rst pulses", {rxf_rst, txf_rst}, 0);
  endtask

  task automatic t_ctl();
    wr_ctl(9'h017);
    chk("R2 pulses", {rxf_rst, txf_rst}, 2'b11);
    chk("R2 readback", ctl_rdata, 9'h014);
    chk("R3 both on", {rx_en, tx_en}, 2'b11);
    @(negedge clk);
    chk("R2 one cycle", {rxf_rst, txf_rst}, 2'b00);
    wr_ctl(9'h016);
    chk("R2 tx only", {rxf_rst, txf_rst}, 2'b01);
    wr_ctl(9'h01C);
    chk("R2 no pulse", {rxf_rst, txf_rst}, 2'b00);
    chk("R3 rx disable wins", {rx_en, tx_en}, 2'b01);
    wr_ctl(9'h034);
    chk("R3 tx disable wins", {rx_en, tx_en}, 2'b10);
    wr_ctl(9'h094);
    chk("R4 break on", brk_req, 1);
    wr_ctl(9'h194);
    chk("R4 stop wins", brk_req, 0);
    wr_ctl(9'h014);
  endtask

  task automatic t_line(input logic [1:0] m, input logic xr, input logic xt, input logic [7:0] d);
    wr_mode(m);
    chk("R5 chan_mode", chan_mode, m);
    chk("R5 mode readback", mode_rdata, {m, 8'h3C});
    ln_valid = 1; ln_data = d; #1;
    chk("R6 rx push", rxf_push, xr);
    chk("R6 tx push", txf_push, xt);
    if (xr) chk("R6 rx data", rxf_wdata, d);
    if (xt) chk("R6 tx data", txf_wdata, d);
    chk("R6 ready", ln_ready, 1);
    ln_valid = 0;
  endtask

  task automatic t_bus(input logic [1:0] m, input logic xr, input logic xt, input logic [7:0] d);
    wr_mode(m);
    bw_valid = 1; bw_data = d; #1;
    chk("R7 rx push", rxf_push, xr);
    chk("R7 tx push", txf_push, xt);
    if (xr) chk("R7 rx data", rxf_wdata, d);
    if (xt) chk("R7 tx data", txf_wdata, d);
    chk("R7 bw_ready", bw_ready, 1);
    bw_valid = 0;
  endtask

  task automatic t_disabled();
    wr_ctl(9'h028);
    wr_mode(2'd0);
    rxf_full = 1; txf_full = 1;
    ln_valid = 1; ln_data = 8'h11; bw_valid = 1; bw_data = 8'h22; #1;
    chk("R8 no push", {rxf_push, txf_push}, 0);
    chk("R8 no events", {rx_ovr, tx_ovf}, 0);
    idle_inputs();
    wr_ctl(9'h014);
  endtask

  task automatic t_rx_full();
    wr_mode(2'd0);
    rxf_full = 1; ln_valid = 1; ln_data = 8'h33; #1;
    chk("R9 line drop", rxf_push, 0);
    chk("R9 rx_ovr line", rx_ovr, 1);
    ln_valid = 0; #1;
    chk("R9 event ends", rx_ovr, 0);
    wr_mode(2'd2);
    bw_valid = 1; bw_data = 8'h44; #1;
    chk("R9 bus drop", rxf_push, 0);
    chk("R9 rx_ovr bus", rx_ovr, 1);
    idle_inputs();
  endtask

  task automatic t_tx_full();
    wr_mode(2'd0);
    txf_full = 1; bw_valid = 1; bw_data = 8'h55; #1;
    chk("R10 bus drop", txf_push, 0);
    chk("R10 tx_ovf bus", tx_ovf, 1);
    bw_valid = 0;
    wr_mode(2'd3);
    ln_valid = 1; ln_data = 8'h66; #1;
    chk("R10 remote ready", ln_ready, 1);
    chk("R10 line drop", txf_push, 0);
    chk("R10 tx_ovf line", tx_ovf, 1);
    idle_inputs();
  endtask

  task automatic t_echo();
    wr_mode(2'd1);
    ln_valid = 1; ln_data = 8'h77; rxf_full = 1; #1;
    chk("R11 stall rx full", ln_ready, 0);
    chk("R11 no push", {rxf_push, txf_push}, 0);
    chk("R11 no event", {rx_ovr, tx_ovf}, 0);
    rxf_full = 0; txf_full = 1; #1;
    chk("R11 stall tx full", ln_ready, 0);
    chk("R11 no push tx", {rxf_push, txf_push}, 0);
    txf_full = 0; #1;
    chk("R11 room ready", ln_ready, 1);
    chk("R11 both push", {rxf_push, txf_push}, 2'b11);
    idle_inputs();
  endtask

  task automatic t_read();
    wr_ctl(9'h014);
    rxf_empty = 0; rxf_rdata = 8'h5A; rd_req = 1; #1;
    chk("R12 data", rd_data, 8'h5A);
    chk("R12 pop", rxf_pop, 1);
    rxf_empty = 1; #1;
    chk("R12 empty zero", rd_data, 0);
    chk("R12 empty no pop", rxf_pop, 0);
    rd_req = 0;
    wr_ctl(9'h01C);
    rxf_empty = 0; rd_req = 1; #1;
    chk("R12 disabled zero", rd_data, 0);
    chk("R12 disabled no pop", rxf_pop, 0);
    idle_inputs();
    wr_ctl(9'h014);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_ctl();
    t_line(2'd0, 1, 0, 8'hA1);
    t_line(2'd1, 1, 1, 8'hB2);
    t_line(2'd2, 0, 0, 8'hC3);
    t_line(2'd3, 0, 1, 8'hD4);
    t_bus(2'd0, 0, 1, 8'hE5);
    t_bus(2'd1, 0, 0, 8'hF6);
    t_bus(2'd2, 1, 0, 8'h07);
    t_bus(2'd3, 0, 0, 8'h18);
    t_disabled();
    t_rx_full();
    t_tx_full();
    t_echo();
    t_read();
    @(negedge clk);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule